// File: doc/BRIEF.md
# Queued Command Completion Tracker

This block keeps the bookkeeping for up to 32 tagged queued commands on one storage port. Each new command arrives as a tag byte, a two-byte sector count and six address bytes. The block takes the tag from the upper five bits of the tag byte. It refuses a tag that is still outstanding. It accepts any free tag, marks it in use and active, and presents the decoded tag, count and address one cycle later.

Commands may complete in any order. Each completion moves its tag from the in-use set into a pending-finished bitmap. When the host asks for a flush and the receive area is enabled, the block emits one status frame for all pending completions. The frame holds a fixed flags byte, the masked device status, the device error byte and the finished bitmap as its payload. In the same cycle the block merges the new status into the task-file value, retires the finished tags from the active bitmap and raises one of two interrupt requests.

Top module: `qct_tracker`

## Requirements
- R1: The command tag is bits [7:3] of the tag byte. A command with a free tag sets that tag's in-use and active bits, and pulses acc_valid with the decoded tag one cycle after it is presented.
- R2: A command whose tag is still in use pulses acc_reject and not acc_valid. The in-use, active and finished bitmaps and the held acc_tag, acc_count and acc_addr values stay as they were.
- R3: The accepted sector count is (high byte << 8) | low byte. A value of zero is reported as 65536 (17'h10000).
- R4: The accepted block address is 48 bits wide. Address byte 5 occupies bits [47:40] and byte 0 occupies bits [7:0].
- R5: A completion for an in-use tag sets that tag's finished bit and clears its in-use bit on the same clock edge. A completion for a tag that is not in use changes nothing.
- R6: A flush with rx_enable high gives frame_valid for one cycle. The frame carries flags 8'h40, status dev_status & 8'h77, error dev_error, and the finished bitmap as it stood before the flush as payload.
- R7: On that flush, the task file becomes {dev_error, (dev_status & 8'h77) | (old & 8'h88)}. The active bitmap loses the payload bits. The finished bitmap drops the payload bits and keeps only a completion recorded in the same cycle.
- R8: Together with the frame, irq_tfe pulses if bit 0 (the error bit) of the masked status is set. Otherwise irq_sdb pulses. The two never pulse together.
- R9: A flush with rx_enable low emits no frame and no interrupt and leaves the task file, active and finished bitmaps unchanged. Completions recorded meanwhile are carried by the next enabled frame.
- R10: After reset the task file reads 16'h007F, every bitmap is zero, and no strobe or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | New command present |
| cmd_tag_byte | input | 8 | Tag byte, tag in bits [7:3] |
| cmd_cnt_lo | input | 8 | Sector count low byte |
| cmd_cnt_hi | input | 8 | Sector count high byte |
| cmd_addr_bytes | input | 6x8 | Address bytes, index 5 most significant |
| done_valid | input | 1 | A command completed |
| done_tag | input | 5 | Tag of the completed command |
| flush_req | input | 1 | Request a status frame |
| rx_enable | input | 1 | Receive area enabled |
| dev_status | input | 8 | Device status byte |
| dev_error | input | 8 | Device error byte |
| acc_valid | output | 1 | Command accepted strobe |
| acc_reject | output | 1 | Tag-in-use rejection strobe |
| acc_tag | output | 5 | Tag of last accepted command |
| acc_count | output | 17 | Sector count of last accepted command |
| acc_addr | output | 48 | Block address of last accepted command |
| frame_valid | output | 1 | Status frame strobe |
| frame_flags | output | 8 | Frame flags byte |
| frame_status | output | 8 | Frame status byte |
| frame_error | output | 8 | Frame error byte |
| frame_payload | output | 32 | Finished-tag bitmap |
| taskfile | output | 16 | Task-file value, error in [15:8] |
| active_map | output | 32 | Active tag bitmap |
| inuse_map | output | 32 | In-use tag bitmap |
| finished_map | output | 32 | Pending-finished bitmap |
| irq_sdb | output | 1 | Set-device-bits interrupt pulse |
| irq_tfe | output | 1 | Task-file-error interrupt pulse |

## Verification
A wrong in-use bit shows at the ports on the next command for that tag. A free tag is then refused, or a busy tag is accepted. Either appears one cycle later on acc_valid or acc_reject, and the bitmap outputs show it at once. A lost or doubled finished bit shows as a wrong payload in the next enabled frame. The same bit also leaves an active bit that should have been cleared, or clears one that should have stayed. A bad merge of the task file shows on the first flush, and bits 7 and 3 persist wrongly through every flush after it.

// File: rtl/qct_pkg.sv
package qct_pkg;
   localparam logic [7:0] FLAGS_IRQ  = 8'h40;
   localparam logic [7:0] STAT_MASK  = 8'h77;
   localparam logic [7:0] TF_HOLD    = 8'h88;
   localparam logic [15:0] TF_RESET  = 16'h007F;
   localparam int unsigned TAG_LSB   = 3;
   localparam int unsigned CNT_W     = 17;

   function automatic logic [CNT_W-1:0] sector_count(input logic [7:0] lo, input logic [7:0] hi);
      logic [15:0] raw;
      raw = {hi, lo};
      return (raw == 16'd0) ? 17'h10000 : {1'b0, raw};
   endfunction
endpackage

// File: rtl/qct_intake.sv
module qct_intake import qct_pkg::*; #(
   parameter int unsigned TAG_W      = 5,
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned NTAG      = 1 << TAG_W,
   localparam int unsigned ADDR_W    = 8 * ADDR_BYTES
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cmd_valid,
   input  logic [7:0]                        cmd_tag_byte,
   input  logic [7:0]                        cmd_cnt_lo,
   input  logic [7:0]                        cmd_cnt_hi,
   input  logic [ADDR_BYTES-1:0][7:0]        cmd_addr_bytes,
   input  logic [NTAG-1:0]                   inuse_map,
   output logic                              take,
   output logic [TAG_W-1:0]                  take_tag,
   output logic                              acc_valid,
   output logic                              acc_reject,
   output logic [TAG_W-1:0]                  acc_tag,
   output logic [CNT_W-1:0]                  acc_count,
   output logic [ADDR_W-1:0]                 acc_addr
);
   logic [ADDR_W-1:0] addr_c;
   logic              busy;

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
      assign addr_c[8*b +: 8] = cmd_addr_bytes[b];
   end

   assign take_tag = cmd_tag_byte[TAG_LSB +: TAG_W];
   assign busy     = inuse_map[take_tag];
   assign take     = cmd_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid  <= 1'b0;
         acc_reject <= 1'b0;
         acc_tag    <= '0;
         acc_count  <= '0;
         acc_addr   <= '0;
      end else begin
         acc_valid  <= take;
         acc_reject <= cmd_valid && busy;
         if (take) begin
            acc_tag   <= take_tag;
            acc_count <= sector_count(cmd_cnt_lo, cmd_cnt_hi);
            acc_addr  <= addr_c;
         end
      end
   end
endmodule

// File: rtl/qct_slots.sv
module qct_slots #(
   parameter int unsigned TAG_W = 5,
   localparam int unsigned NTAG = 1 << TAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [TAG_W-1:0] take_tag,
   input  logic             done_valid,
   input  logic [TAG_W-1:0] done_tag,
   input  logic             flush_fire,
   output logic [NTAG-1:0]  inuse_map,
   output logic [NTAG-1:0]  finished_map
);
   for (genvar t = 0; t < NTAG; t++) begin : g_slot
      logic hit_new, hit_done;
      assign hit_new  = take && (take_tag == TAG_W'(t));
      assign hit_done = done_valid && (done_tag == TAG_W'(t)) && inuse_map[t];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            inuse_map[t]    <= 1'b0;
            finished_map[t] <= 1'b0;
         end else begin
            if (hit_done)     inuse_map[t] <= 1'b0;
            else if (hit_new) inuse_map[t] <= 1'b1;
            if (hit_done)        finished_map[t] <= 1'b1;
            else if (flush_fire) finished_map[t] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/qct_flush.sv
module qct_flush import qct_pkg::*; #(
   parameter int unsigned TAG_W = 5,
   localparam int unsigned NTAG = 1 << TAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_fire,
   input  logic [NTAG-1:0]  finished_map,
   input  logic [7:0]       dev_status,
   input  logic [7:0]       dev_error,
   input  logic             take,
   input  logic [TAG_W-1:0] take_tag,
   output logic             frame_valid,
   output logic [7:0]       frame_flags,
   output logic [7:0]       frame_status,
   output logic [7:0]       frame_error,
   output logic [NTAG-1:0]  frame_payload,
   output logic [15:0]      taskfile,
   output logic [NTAG-1:0]  active_map,
   output logic             irq_sdb,
   output logic             irq_tfe
);
   logic [7:0]      stat_m;
   logic [NTAG-1:0] new_bit;
   logic [NTAG-1:0] clr_bits;

   assign stat_m   = dev_status & STAT_MASK;
   assign new_bit  = take ? (NTAG'(1) << take_tag) : '0;
   assign clr_bits = flush_fire ? finished_map : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid   <= 1'b0;
         frame_flags   <= '0;
         frame_status  <= '0;
         frame_error   <= '0;
         frame_payload <= '0;
         taskfile      <= TF_RESET;
         active_map    <= '0;
         irq_sdb       <= 1'b0;
         irq_tfe       <= 1'b0;
      end else begin
         frame_valid <= flush_fire;
         irq_tfe     <= flush_fire && stat_m[0];
         irq_sdb     <= flush_fire && !stat_m[0];
         active_map  <= (active_map & ~clr_bits) | new_bit;
         if (flush_fire) begin
            frame_flags   <= FLAGS_IRQ;
            frame_status  <= stat_m;
            frame_error   <= dev_error;
            frame_payload <= finished_map;
            taskfile      <= {dev_error, stat_m | (taskfile[7:0] & TF_HOLD)};
         end
      end
   end
endmodule

// File: rtl/qct_tracker.sv
module qct_tracker import qct_pkg::*; #(
   parameter int unsigned TAG_W      = 5,
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned NTAG      = 1 << TAG_W,
   localparam int unsigned ADDR_W    = 8 * ADDR_BYTES
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [7:0]                 cmd_tag_byte,
   input  logic [7:0]                 cmd_cnt_lo,
   input  logic [7:0]                 cmd_cnt_hi,
   input  logic [ADDR_BYTES-1:0][7:0] cmd_addr_bytes,
   input  logic                       done_valid,
   input  logic [TAG_W-1:0]           done_tag,
   input  logic                       flush_req,
   input  logic                       rx_enable,
   input  logic [7:0]                 dev_status,
   input  logic [7:0]                 dev_error,
   output logic                       acc_valid,
   output logic                       acc_reject,
   output logic [TAG_W-1:0]           acc_tag,
   output logic [CNT_W-1:0]           acc_count,
   output logic [ADDR_W-1:0]          acc_addr,
   output logic                       frame_valid,
   output logic [7:0]                 frame_flags,
   output logic [7:0]                 frame_status,
   output logic [7:0]                 frame_error,
   output logic [NTAG-1:0]            frame_payload,
   output logic [15:0]                taskfile,
   output logic [NTAG-1:0]            active_map,
   output logic [NTAG-1:0]            inuse_map,
   output logic [NTAG-1:0]            finished_map,
   output logic                       irq_sdb,
   output logic                       irq_tfe
);
   if (TAG_W < 1 || TAG_W > 5) begin : g_bad_tag
      $error("qct_tracker: TAG_W must lie in 1..5");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 8) begin : g_bad_addr
      $error("qct_tracker: ADDR_BYTES must lie in 1..8");
   end

   logic             take;
   logic [TAG_W-1:0] take_tag;
   logic             flush_fire;

   assign flush_fire = flush_req && rx_enable;

   qct_intake #(.TAG_W(TAG_W), .ADDR_BYTES(ADDR_BYTES)) intake_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tag_byte(cmd_tag_byte),
      .cmd_cnt_lo(cmd_cnt_lo), .cmd_cnt_hi(cmd_cnt_hi), .cmd_addr_bytes(cmd_addr_bytes),
      .inuse_map(inuse_map), .take(take), .take_tag(take_tag), .acc_valid(acc_valid),
      .acc_reject(acc_reject), .acc_tag(acc_tag), .acc_count(acc_count), .acc_addr(acc_addr));

   qct_slots #(.TAG_W(TAG_W)) slots_i (
      .clk(clk), .rst_n(rst_n), .take(take), .take_tag(take_tag), .done_valid(done_valid),
      .done_tag(done_tag), .flush_fire(flush_fire), .inuse_map(inuse_map),
      .finished_map(finished_map));

   qct_flush #(.TAG_W(TAG_W)) flush_i (
      .clk(clk), .rst_n(rst_n), .flush_fire(flush_fire), .finished_map(finished_map),
      .dev_status(dev_status), .dev_error(dev_error), .take(take), .take_tag(take_tag),
      .frame_valid(frame_valid), .frame_flags(frame_flags), .frame_status(frame_status),
      .frame_error(frame_error), .frame_payload(frame_payload), .taskfile(taskfile),
      .active_map(active_map), .irq_sdb(irq_sdb), .irq_tfe(irq_tfe));
endmodule

// File: rtl/qct_tracker_chk.sv
module qct_tracker_chk #(
   parameter int unsigned TAG_W = 5,
   localparam int unsigned NTAG = 1 << TAG_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [7:0]       cmd_tag_byte,
   input logic             done_valid,
   input logic [TAG_W-1:0] done_tag,
   input logic             flush_req,
   input logic             rx_enable,
   input logic             acc_valid,
   input logic             acc_reject,
   input logic             frame_valid,
   input logic [7:0]       frame_flags,
   input logic [7:0]       frame_status,
   input logic [15:0]      taskfile,
   input logic [NTAG-1:0]  inuse_map,
   input logic [NTAG-1:0]  finished_map,
   input logic             irq_sdb,
   input logic             irq_tfe
);
   a_r2_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && inuse_map[cmd_tag_byte[3 +: TAG_W]] |=> acc_reject && !acc_valid);

   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && inuse_map[done_tag] |=> !inuse_map[$past(done_tag)] && finished_map[$past(done_tag)]);

   a_r6_flags_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> frame_flags == 8'h40 && (frame_status & 8'h88) == 8'h00);

   a_r7_tf_hold_bits: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> taskfile[7] == $past(taskfile[7]) && taskfile[3] == $past(taskfile[3]));

   a_r8_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_sdb && irq_tfe) && ((irq_sdb || irq_tfe) == frame_valid));

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req && !rx_enable |=> !frame_valid && $stable(taskfile));
endmodule

bind qct_tracker qct_tracker_chk #(.TAG_W(TAG_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tag_byte(cmd_tag_byte),
   .done_valid(done_valid), .done_tag(done_tag), .flush_req(flush_req), .rx_enable(rx_enable),
   .acc_valid(acc_valid), .acc_reject(acc_reject), .frame_valid(frame_valid),
   .frame_flags(frame_flags), .frame_status(frame_status), .taskfile(taskfile),
   .inuse_map(inuse_map), .finished_map(finished_map), .irq_sdb(irq_sdb), .irq_tfe(irq_tfe));

// File: tb/qct_tracker_tb.sv
module qct_tracker_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 0, done_valid = 0, flush_req = 0, rx_enable = 0;
   logic [7:0] cmd_tag_byte = 0, cmd_cnt_lo = 0, cmd_cnt_hi = 0, dev_status = 0, dev_error = 0;
   logic [5:0][7:0] cmd_addr_bytes = '0;
   logic [4:0] done_tag = 0;
   logic acc_valid, acc_reject, frame_valid, irq_sdb, irq_tfe;
   logic [4:0] acc_tag;
   logic [16:0] acc_count;
   logic [47:0] acc_addr;
   logic [7:0] frame_flags, frame_status, frame_error;
   logic [31:0] frame_payload, active_map, inuse_map, finished_map;
   logic [15:0] taskfile;

   int checks = 0, errors = 0;
   logic [31:0] m_inuse = 0, m_fin = 0, m_act = 0;
   logic [15:0] m_tf = 16'h007F;

   always #(CLK_PERIOD/2) clk = ~clk;

   qct_tracker dut_i (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [16:0] exp_count(input logic [7:0] lo, input logic [7:0] hi);
      return ({hi, lo} == 16'd0) ? 17'h10000 : {1'b0, hi, lo};
   endfunction

   function automatic logic [47:0] exp_addr(input logic [5:0][7:0] b);
      logic [47:0] a = 0;
      for (int k = 5; k >= 0; k--) a = (a << 8) | 48'(b[k]);
      return a;
   endfunction

   task automatic check_maps(input string req);
      chk({req, " inuse"}, 64'(inuse_map), 64'(m_inuse));
      chk({req, " finished"}, 64'(finished_map), 64'(m_fin));
      chk({req, " active"}, 64'(active_map), 64'(m_act));
      chk({req, " taskfile"}, 64'(taskfile), 64'(m_tf));
   endtask

   task automatic issue(input logic [7:0] tb, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [47:0] ab);
      logic [4:0] t = tb[7:3];
      logic busy = m_inuse[t];
      logic [4:0] prev_tag = acc_tag;
      logic [16:0] prev_cnt = acc_count;
      cmd_valid = 1; cmd_tag_byte = tb; cmd_cnt_lo = lo; cmd_cnt_hi = hi;
      for (int k = 0; k < 6; k++) cmd_addr_bytes[k] = ab[8*k +: 8];
      @(posedge clk); #1;
      cmd_valid = 0;
      if (busy) begin
         chk("R2 reject", {acc_reject, acc_valid}, 2'b10);
         chk("R2 tag held", 64'(acc_tag), 64'(prev_tag));
         chk("R2 count held", 64'(acc_count), 64'(prev_cnt));
      end else begin
         m_inuse[t] = 1; m_act[t] = 1;
         chk("R1 accept", {acc_reject, acc_valid}, 2'b01);
         chk("R1 tag", 64'(acc_tag), 64'(t));
         chk("R3 count", 64'(acc_count), 64'(exp_count(lo, hi)));
         chk("R4 addr", 64'(acc_addr), 64'(exp_addr(cmd_addr_bytes)));
      end
      check_maps(busy ? "R2" : "R1");
   endtask

   task automatic complete(input logic [4:0] t);
      done_valid = 1; done_tag = t;
      @(posedge clk); #1;
      done_valid = 0;
      if (m_inuse[t]) begin m_inuse[t] = 0; m_fin[t] = 1; end
      check_maps("R5");
   endtask

   task automatic flush(input logic en, input logic [7:0] st, input logic [7:0] er);
      logic [31:0] pay = m_fin;
      logic [7:0] sm = st & 8'h77;
      flush_req = 1; rx_enable = en; dev_status = st; dev_error = er;
      @(posedge clk); #1;
      flush_req = 0;
      if (en) begin
         chk("R6 valid", 64'(frame_valid), 1);
         chk("R6 flags", 64'(frame_flags), 64'h40);
         chk("R6 status", 64'(frame_status), 64'(sm));
         chk("R6 error", 64'(frame_error), 64'(er));
         chk("R6 payload", 64'(frame_payload), 64'(pay));
         chk("R8 irq", {irq_tfe, irq_sdb}, sm[0] ? 2'b10 : 2'b01);
         m_tf = {er, sm | (m_tf[7:0] & 8'h88)};
         m_act &= ~pay; m_fin = 0;
         check_maps("R7");
      end else begin
         chk("R9 no frame", {frame_valid, irq_tfe, irq_sdb}, 3'b000);
         check_maps("R9");
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      #(CLK_PERIOD * 2 + 1);
      check_maps("R10");
      chk("R10 strobes", {acc_valid, acc_reject, frame_valid, irq_sdb, irq_tfe}, 5'b0);
      rst_n = 1;
      @(posedge clk); #1;
      // directed corners
      issue(8'b10101_011, 8'h00, 8'h00, 48'hA1B2C3D4E5F6);  // count 0 -> 65536, tag 21
      issue(8'b10101_000, 8'h34, 8'h12, 48'h1);             // busy tag, low bits differ
      issue(8'b00000_111, 8'h01, 8'h00, 48'hFF0000000000);  // tag 0
      complete(5'd7);                                       // not in use: ignored
      complete(5'd21);
      complete(5'd21);                                      // second done ignored
      flush(1'b0, 8'h50, 8'h00);                            // disabled, kept
      complete(5'd0);
      issue(8'b10101_000, 8'hFF, 8'hFF, 48'h123456789ABC); // freed tag reused
      flush(1'b1, 8'hFF, 8'h04);                            // error bit set
      flush(1'b1, 8'h50, 8'h00);                            // empty payload, sdb
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int op = $urandom_range(0, 9);
         if (op < 4) issue(8'($urandom), 8'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                           8'($urandom_range(0, 3) == 0 ? 0 : $urandom), {$urandom, $urandom});
         else if (op < 8) complete(5'($urandom));
         else flush(1'($urandom_range(0, 3) != 0), 8'($urandom), 8'($urandom));
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule